// File: doc/BRIEF.md
# Checksummed Serial Frame Codec

This block prepares and inspects the 32-bit words exchanged with a chain of battery-monitor devices over a serial link. On the transmit side it assembles a write command from a device address, a register address, a data byte and a broadcast flag. It appends an 8-bit checksum and a fixed three-bit trailer, and presents the word one clock later. A separate request selects the constant word that clocks one readback response out of the chain.

On the receive side a 32-bit word is checked in the same cycle it is presented. The block computes a checksum over the upper 22 bits and compares it with the eight bits below them. It extracts the device address, the index and the payload according to the frame kind, which is either a conversion result or a register readback. It also compares the address and index against expected values, and flags an all-zero word, which marks the end of the chain. Shifting the bits on the wire is done elsewhere; words cross this block in parallel.

The checksum uses the polynomial 0x2F. Each byte step shifts left eight times, and XORs the polynomial after every shift whose outgoing bit 7 was one. Over a value v of up to 24 bits, the first step runs on v[23:16]. The second step runs on that result XOR v[15:8]. The checksum is the second result XOR v[7:0].

Top module: `frame_codec`

## Requirements
- R1: While reset is asserted and after it, until the first accepted request, tx_word_valid is 0 and tx_word is 0.
- R2: tx_word_valid is high in exactly the cycle after a cycle with tx_valid high; tx_word updates only on accepted requests and holds otherwise.
- R3: A write word has the device address in [31:27], the register address in [26:21], the data byte in [20:13], the broadcast flag in [12], a 0 in [11] and the trailer 3'b010 in [2:0].
- R4: Bits [10:3] of a write word hold the checksum of bits [31:11] taken as a 21-bit value.
- R5: With tx_readout high on an accepted request, tx_word is 32'hF800030A whatever the other transmit inputs are.
- R6: With rx_valid high, exactly one of rx_crc_ok and rx_crc_err is high in the same cycle. rx_crc_ok is high when the checksum of rx_word[31:10] equals rx_word[9:2].
- R7: With rx_kind = 0 (conversion result), rx_dev is [31:27], rx_idx is [26:23] zero-extended to 6 bits, and rx_data is [22:11].
- R8: With rx_kind = 1 (register readback), rx_dev is [31:27], rx_idx is [26:21], and rx_data is [20:13] zero-extended to 12 bits.
- R9: With rx_valid high, rx_addr_err is high when rx_dev differs from rx_exp_dev or rx_idx differs from rx_exp_idx, regardless of the checksum verdict.
- R10: With rx_valid low, rx_crc_ok, rx_crc_err, rx_addr_err and rx_empty are 0, and rx_dev, rx_idx and rx_data are 0.
- R11: With rx_valid high, rx_empty is high when all 32 bits of rx_word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit request accepted this cycle |
| tx_readout | input | 1 | Request the fixed readback-clocking word instead of a write |
| tx_dev_addr | input | 5 | Target device address |
| tx_reg_addr | input | 6 | Target register address |
| tx_data | input | 8 | Data byte to write |
| tx_bcast | input | 1 | Broadcast flag |
| tx_word_valid | output | 1 | tx_word was loaded on the last edge |
| tx_word | output | 32 | Assembled outgoing word |
| rx_valid | input | 1 | A received word is presented |
| rx_kind | input | 1 | 0 = conversion result, 1 = register readback |
| rx_word | input | 32 | Received word |
| rx_exp_dev | input | 5 | Expected device address |
| rx_exp_idx | input | 6 | Expected channel or register index |
| rx_crc_ok | output | 1 | Checksum matches |
| rx_crc_err | output | 1 | Checksum mismatch |
| rx_addr_err | output | 1 | Address or index mismatch |
| rx_empty | output | 1 | All-zero word (end of chain) |
| rx_dev | output | 5 | Extracted device address |
| rx_idx | output | 6 | Extracted channel or register index |
| rx_data | output | 12 | Extracted result or register value |

## Verification
The transmit word and its valid flag come from one register stage, so the bench predicts them at the rising edge that samples a request and compares them at the following falling edge. All receive results are combinational, so they are compared at the falling edge of the same cycle in which the word is applied, before the next word is driven. Received frames are built with correct checksums and then sometimes corrupted. Expected address and index values either match the frame or are drawn at random, so both verdicts appear in both frame kinds.

// File: rtl/frame_codec_pkg.sv
package frame_codec_pkg;

   localparam logic [31:0] READOUT_WORD = 32'hF800_030A;
   localparam logic [2:0]  WR_TRAILER   = 3'b010;

   typedef enum logic {
      FRM_CONV = 1'b0,
      FRM_RDBK = 1'b1
   } frame_kind_e;

   // one byte through eight shift-and-reduce steps
   function automatic logic [7:0] crc_byte_step(input logic [7:0] b, input logic [7:0] poly);
      logic [7:0] c;
      c = b;
      for (int i = 0; i < 8; i++) begin
         c = c[7] ? ((c << 1) ^ poly) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/frame_crc8_fold.sv
module frame_crc8_fold
   import frame_codec_pkg::*;
#(
   parameter logic [7:0] POLY    = 8'h2F,
   parameter int         IN_W    = 22,
   parameter bit         USE_LUT = 1'b0
) (
   input  logic [IN_W-1:0] din,
   output logic [7:0]      crc
);

   localparam int FOLD_W = 24;

   generate
      if (IN_W < 17 || IN_W > FOLD_W) begin : g_bad_width
         $error("frame_crc8_fold: IN_W must lie in 17..24");
      end
   endgenerate

   logic [FOLD_W-1:0] v;
   logic [7:0]        s1;
   logic [7:0]        s2;

   assign v = FOLD_W'(din);

   generate
      if (USE_LUT) begin : g_lut
         logic [7:0] lut [256];
         for (genvar g = 0; g < 256; g++) begin : g_entry
            assign lut[g] = crc_byte_step(8'(g), POLY);
         end
         assign s1 = lut[v[23:16]];
         assign s2 = lut[s1 ^ v[15:8]];
      end else begin : g_calc
         assign s1 = crc_byte_step(v[23:16], POLY);
         assign s2 = crc_byte_step(s1 ^ v[15:8], POLY);
      end
   endgenerate

   assign crc = s2 ^ v[7:0];

endmodule

// File: rtl/frame_tx_build.sv
module frame_tx_build
   import frame_codec_pkg::*;
#(
   parameter int         DEV_W   = 5,
   parameter int         REG_W   = 6,
   parameter int         DATA_W  = 8,
   parameter int         WORD_W  = 32,
   parameter logic [7:0] POLY    = 8'h2F,
   parameter bit         USE_LUT = 1'b0
) (
   input  logic [DEV_W-1:0]  dev_addr,
   input  logic [REG_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0] data,
   input  logic              bcast,
   input  logic              readout,
   output logic [WORD_W-1:0] word
);

   localparam int HDR_W = DEV_W + REG_W + DATA_W + 2;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("frame_tx_build: WORD_W must be 32");
      end
      if (HDR_W + 8 + 3 != WORD_W) begin : g_bad_fields
         $error("frame_tx_build: header, checksum and trailer must fill the word");
      end
   endgenerate

   logic [HDR_W-1:0] hdr;
   logic [7:0]       crc;
   logic [WORD_W-1:0] wr_word;

   assign hdr = {dev_addr, reg_addr, data, bcast, 1'b0};

   frame_crc8_fold #(
      .POLY    (POLY),
      .IN_W    (HDR_W),
      .USE_LUT (USE_LUT)
   ) u_crc (
      .din (hdr),
      .crc (crc)
   );

   assign wr_word = {hdr, crc, WR_TRAILER};
   assign word    = readout ? READOUT_WORD : wr_word;

endmodule

// File: rtl/frame_rx_parse.sv
module frame_rx_parse
   import frame_codec_pkg::*;
#(
   parameter int         DEV_W   = 5,
   parameter int         REG_W   = 6,
   parameter int         DATA_W  = 8,
   parameter int         CH_W    = 4,
   parameter int         RES_W   = 12,
   parameter int         WORD_W  = 32,
   parameter logic [7:0] POLY    = 8'h2F,
   parameter bit         USE_LUT = 1'b0
) (
   input  logic              valid,
   input  logic              kind,
   input  logic [WORD_W-1:0] word,
   input  logic [DEV_W-1:0]  exp_dev,
   input  logic [REG_W-1:0]  exp_idx,
   output logic              crc_ok,
   output logic              crc_err,
   output logic              addr_err,
   output logic              empty,
   output logic [DEV_W-1:0]  dev,
   output logic [REG_W-1:0]  idx,
   output logic [RES_W-1:0]  data
);

   localparam int CHK_LO  = 10;
   localparam int CHK_W   = WORD_W - CHK_LO;
   localparam int DEV_LO  = WORD_W - DEV_W;
   localparam int CH_LO   = DEV_LO - CH_W;
   localparam int RES_LO  = CH_LO - RES_W;
   localparam int REG_LO  = DEV_LO - REG_W;
   localparam int VAL_LO  = REG_LO - DATA_W;

   generate
      if (CH_W > REG_W || DATA_W > RES_W) begin : g_bad_fields
         $error("frame_rx_parse: narrow fields must fit the wide outputs");
      end
      if (RES_LO < CHK_LO || VAL_LO < CHK_LO) begin : g_bad_overlap
         $error("frame_rx_parse: payload overlaps the checksum");
      end
   endgenerate

   logic [7:0]       crc_calc;
   logic             crc_match;
   logic [DEV_W-1:0] f_dev;
   logic [REG_W-1:0] f_idx;
   logic [RES_W-1:0] f_data;

   frame_crc8_fold #(
      .POLY    (POLY),
      .IN_W    (CHK_W),
      .USE_LUT (USE_LUT)
   ) u_crc (
      .din (word[WORD_W-1:CHK_LO]),
      .crc (crc_calc)
   );

   assign crc_match = (crc_calc == word[CHK_LO-1:CHK_LO-8]);
   assign f_dev     = word[WORD_W-1:DEV_LO];

   always_comb begin
      if (frame_kind_e'(kind) == FRM_CONV) begin
         f_idx  = REG_W'(word[DEV_LO-1:CH_LO]);
         f_data = word[CH_LO-1:RES_LO];
      end else begin
         f_idx  = word[DEV_LO-1:REG_LO];
         f_data = RES_W'(word[REG_LO-1:VAL_LO]);
      end
   end

   assign crc_ok   = valid & crc_match;
   assign crc_err  = valid & ~crc_match;
   assign addr_err = valid & ((f_dev != exp_dev) | (f_idx != exp_idx));
   assign empty    = valid & (word == '0);
   assign dev      = valid ? f_dev  : '0;
   assign idx      = valid ? f_idx  : '0;
   assign data     = valid ? f_data : '0;

endmodule

// File: rtl/frame_codec.sv
module frame_codec
   import frame_codec_pkg::*;
#(
   parameter int         DEV_W   = 5,
   parameter int         REG_W   = 6,
   parameter int         DATA_W  = 8,
   parameter int         CH_W    = 4,
   parameter int         RES_W   = 12,
   parameter int         WORD_W  = 32,
   parameter logic [7:0] POLY    = 8'h2F,
   parameter bit         USE_LUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic              tx_readout,
   input  logic [DEV_W-1:0]  tx_dev_addr,
   input  logic [REG_W-1:0]  tx_reg_addr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_bcast,
   output logic              tx_word_valid,
   output logic [WORD_W-1:0] tx_word,
   input  logic              rx_valid,
   input  logic              rx_kind,
   input  logic [WORD_W-1:0] rx_word,
   input  logic [DEV_W-1:0]  rx_exp_dev,
   input  logic [REG_W-1:0]  rx_exp_idx,
   output logic              rx_crc_ok,
   output logic              rx_crc_err,
   output logic              rx_addr_err,
   output logic              rx_empty,
   output logic [DEV_W-1:0]  rx_dev,
   output logic [REG_W-1:0]  rx_idx,
   output logic [RES_W-1:0]  rx_data
);

   logic [WORD_W-1:0] tx_next;

   frame_tx_build #(
      .DEV_W   (DEV_W),
      .REG_W   (REG_W),
      .DATA_W  (DATA_W),
      .WORD_W  (WORD_W),
      .POLY    (POLY),
      .USE_LUT (USE_LUT)
   ) u_tx (
      .dev_addr (tx_dev_addr),
      .reg_addr (tx_reg_addr),
      .data     (tx_data),
      .bcast    (tx_bcast),
      .readout  (tx_readout),
      .word     (tx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_word_valid <= 1'b0;
         tx_word       <= '0;
      end else begin
         tx_word_valid <= tx_valid;
         if (tx_valid) begin
            tx_word <= tx_next;
         end
      end
   end

   frame_rx_parse #(
      .DEV_W   (DEV_W),
      .REG_W   (REG_W),
      .DATA_W  (DATA_W),
      .CH_W    (CH_W),
      .RES_W   (RES_W),
      .WORD_W  (WORD_W),
      .POLY    (POLY),
      .USE_LUT (USE_LUT)
   ) u_rx (
      .valid    (rx_valid),
      .kind     (rx_kind),
      .word     (rx_word),
      .exp_dev  (rx_exp_dev),
      .exp_idx  (rx_exp_idx),
      .crc_ok   (rx_crc_ok),
      .crc_err  (rx_crc_err),
      .addr_err (rx_addr_err),
      .empty    (rx_empty),
      .dev      (rx_dev),
      .idx      (rx_idx),
      .data     (rx_data)
   );

endmodule

// File: rtl/frame_codec_chk.sv
module frame_codec_chk #(
   parameter int DEV_W  = 5,
   parameter int REG_W  = 6,
   parameter int DATA_W = 8,
   parameter int RES_W  = 12,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_valid,
   input logic              tx_readout,
   input logic [DEV_W-1:0]  tx_dev_addr,
   input logic              tx_word_valid,
   input logic [WORD_W-1:0] tx_word,
   input logic              rx_valid,
   input logic              rx_crc_ok,
   input logic              rx_crc_err,
   input logic              rx_addr_err,
   input logic              rx_empty
);

   assert_wvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> tx_word_valid);

   assert_wvalid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |=> !tx_word_valid);

   assert_trailer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_word_valid |-> (tx_word[2:0] == 3'b010));

   assert_write_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_word_valid && !$past(tx_readout)) |->
         (!tx_word[11] && tx_word[WORD_W-1 -: DEV_W] == $past(tx_dev_addr)));

   assert_readout_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_word_valid && $past(tx_readout)) |-> (tx_word == 32'hF800_030A));

   assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (rx_crc_ok != rx_crc_err));

   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> (!rx_crc_ok && !rx_crc_err && !rx_addr_err && !rx_empty));

   assert_empty_passes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> rx_crc_ok);

endmodule

bind frame_codec frame_codec_chk #(
   .DEV_W  (DEV_W),
   .REG_W  (REG_W),
   .DATA_W (DATA_W),
   .RES_W  (RES_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_valid      (tx_valid),
   .tx_readout    (tx_readout),
   .tx_dev_addr   (tx_dev_addr),
   .tx_word_valid (tx_word_valid),
   .tx_word       (tx_word),
   .rx_valid      (rx_valid),
   .rx_crc_ok     (rx_crc_ok),
   .rx_crc_err    (rx_crc_err),
   .rx_addr_err   (rx_addr_err),
   .rx_empty      (rx_empty)
);

// File: tb/tb_frame_codec.sv
module tb_frame_codec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_valid = 1'b0;
   logic        tx_readout = 1'b0;
   logic [4:0]  tx_dev_addr = '0;
   logic [5:0]  tx_reg_addr = '0;
   logic [7:0]  tx_data = '0;
   logic        tx_bcast = 1'b0;
   logic        tx_word_valid;
   logic [31:0] tx_word;
   logic        rx_valid = 1'b0;
   logic        rx_kind = 1'b0;
   logic [31:0] rx_word = '0;
   logic [4:0]  rx_exp_dev = '0;
   logic [5:0]  rx_exp_idx = '0;
   logic        rx_crc_ok, rx_crc_err, rx_addr_err, rx_empty;
   logic [4:0]  rx_dev;
   logic [5:0]  rx_idx;
   logic [11:0] rx_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state for the registered transmit path
   bit          exp_v = 1'b0;
   int unsigned exp_w = 0;
   bit          exp_ro = 1'b0;

   always #10 clk = ~clk;

   frame_codec dut (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_readout(tx_readout), .tx_dev_addr(tx_dev_addr),
      .tx_reg_addr(tx_reg_addr), .tx_data(tx_data), .tx_bcast(tx_bcast),
      .tx_word_valid(tx_word_valid), .tx_word(tx_word),
      .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_word(rx_word),
      .rx_exp_dev(rx_exp_dev), .rx_exp_idx(rx_exp_idx),
      .rx_crc_ok(rx_crc_ok), .rx_crc_err(rx_crc_err), .rx_addr_err(rx_addr_err),
      .rx_empty(rx_empty), .rx_dev(rx_dev), .rx_idx(rx_idx), .rx_data(rx_data)
   );

   function automatic int unsigned m_step(input int unsigned b);
      int unsigned x;
      x = b & 255;
      for (int k = 0; k < 8; k++) begin
         if (x >= 128) x = ((x * 2) & 255) ^ 47;
         else          x = (x * 2) & 255;
      end
      return x;
   endfunction

   function automatic int unsigned m_crc(input int unsigned v);
      int unsigned c;
      c = m_step((v / 65536) % 256);
      c = m_step(c ^ ((v / 256) % 256));
      return c ^ (v % 256);
   endfunction

   function automatic int unsigned m_tx(input int unsigned dv, input int unsigned rg,
                                        input int unsigned dt, input int unsigned bc);
      int unsigned w;
      w = dv * 134217728 + rg * 2097152 + dt * 8192 + bc * 4096;
      return w + m_crc(w / 2048) * 8 + 2;
   endfunction

   task automatic chk(input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_v <= 1'b0;
         exp_w <= 0;
      end else begin
         exp_v <= tx_valid;
         if (tx_valid) begin
            exp_ro <= tx_readout;
            exp_w  <= tx_readout ? 32'hF800030A :
                      m_tx(tx_dev_addr, tx_reg_addr, tx_data, tx_bcast);
         end
      end
   end

   task automatic check_all();
      int unsigned w, dv, ix, dt;
      bit good;
      chk("R2", "tx_word_valid", tx_word_valid, exp_v);
      if (exp_v) begin
         if (exp_ro) begin
            chk("R5", "readout word", tx_word, exp_w);
         end else begin
            chk("R3", "write fields", {tx_word[31:11], tx_word[2:0]},
                {exp_w[31:11], exp_w[2:0]});
            chk("R4", "write checksum", tx_word[10:3], exp_w[10:3]);
         end
      end
      w = rx_word;
      if (!rx_valid) begin
         chk("R10", "idle flags", {rx_crc_ok, rx_crc_err, rx_addr_err, rx_empty}, 0);
         chk("R10", "idle fields", {rx_dev, rx_idx, rx_data}, 0);
      end else begin
         good = (m_crc(w / 1024) == ((w / 4) % 256));
         chk("R6", "crc verdict", {rx_crc_ok, rx_crc_err}, good ? 2 : 1);
         dv = w / 134217728;
         if (!rx_kind) begin
            ix = (w / 8388608) % 16;
            dt = (w / 2048) % 4096;
            chk("R7", "conversion fields", {rx_dev, rx_idx, rx_data}, {dv[4:0], ix[5:0], dt[11:0]});
         end else begin
            ix = (w / 2097152) % 64;
            dt = (w / 8192) % 256;
            chk("R8", "readback fields", {rx_dev, rx_idx, rx_data}, {dv[4:0], ix[5:0], dt[11:0]});
         end
         chk("R9", "address error", rx_addr_err,
             (dv != rx_exp_dev) || (ix != rx_exp_idx));
         chk("R11", "empty flag", rx_empty, w == 0);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset valid", tx_word_valid, 0);
      chk("R1", "reset word", tx_word, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "post-reset valid", tx_word_valid, 0);
      chk("R1", "post-reset word", tx_word, 0);
      for (int i = 0; i < 600; i++) begin
         int unsigned w, dv, ix;
         tx_valid    = (i < 3) ? 1'b1 : (($urandom % 4) != 0);
         tx_readout  = ((i % 7) == 3);
         tx_dev_addr = 5'($urandom);
         tx_reg_addr = 6'($urandom);
         tx_data     = 8'($urandom);
         tx_bcast    = 1'($urandom);
         if (i == 0) begin
            tx_dev_addr = '1; tx_reg_addr = '1; tx_data = '1; tx_bcast = 1'b1;
         end else if (i == 1) begin
            tx_dev_addr = '0; tx_reg_addr = '0; tx_data = '0; tx_bcast = 1'b0;
         end
         rx_valid = ((i % 5) != 4);
         rx_kind  = 1'($urandom);
         w = $urandom & 32'hFFFF_FC00;
         w = w + m_crc(w / 1024) * 4;
         if ((i % 3) == 1) w = w ^ (32'h4 << ($urandom % 30));
         if ((i % 11) == 0) w = 0;
         rx_word = w;
         dv = w / 134217728;
         ix = rx_kind ? (w / 2097152) % 64 : (w / 8388608) % 16;
         if (($urandom % 2) == 0) begin
            rx_exp_dev = dv[4:0];
            rx_exp_idx = ix[5:0];
         end else begin
            rx_exp_dev = 5'($urandom);
            rx_exp_idx = 6'($urandom);
         end
         @(negedge clk);
         check_all();
      end
      tx_valid = 1'b0;
      rx_valid = 1'b0;
      repeat (2) begin
         @(negedge clk);
         check_all();
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule